// File: doc/BRIEF.md
# Tagged Set-Associative Page Translation Buffer

This block keeps a small cache of recent page translations for a 14-bit virtual address space that maps onto a 12-bit physical space with 64-byte pages. A requester presents a virtual address together with a process number. One cycle later the block reports whether it holds a mapping for that page under that process. On a hit it also returns the physical address, built from the cached frame number and the unchanged byte offset.

A page walker elsewhere writes new translations through the fill port. A fill lands in the set chosen by the page number. It reuses a way that already holds the same page and process, or else the lowest empty way. When the set is full, it takes the way named by that set's rotating victim pointer.

Two invalidation inputs serve context changes. A full flush drops every entry, as needed when the page-table base changes. A selective flush drops only the entries that belong to one named process.

Top module: `xlate_buf`

## Requirements
- R1: After reset, respValid, respHit and respPa are 0, every entry is invalid, and every lookup misses until a fill is made.
- R2: The address is split as offset = VA[5:0], set index = VA[7:6] and tag = VA[13:8]. The fill page number fillVpn[7:0] is split the same way: set = fillVpn[1:0], tag = fillVpn[7:2]. On a hit, respPa = {frame number, VA[5:0]}.
- R3: The result of a lookup appears on the clock edge after the cycle in which lookupValid is high. respValid is 1 in that cycle and 0 after a cycle without a lookup.
- R4: A lookup hits only if the entry in the indexed set is valid, its tag matches and its stored process number equals lookupPid. A mapping filled under one process misses when it is looked up under another.
- R5: On a miss, respHit is 0 and respPa is 0.
- R6: A fill with no matching entry in its set goes to the lowest-numbered invalid way of that set.
- R7: A fill into a full set with no matching entry replaces the way named by that set's round-robin pointer. The pointer starts at 0 after reset and advances by one, wrapping after way 3, on every accepted fill into that set.
- R8: A fill whose tag and process match a valid entry of its set overwrites that entry's frame number in place. No duplicate entry is created.
- R9: A lookup in the same cycle as a fill or a flush sees the contents from before that cycle.
- R10: flushAll invalidates every entry at the next clock edge.
- R11: flushPidValid invalidates, at the next clock edge, only the entries whose process number equals flushPid. All other entries keep their contents.
- R12: While flushAll or flushPidValid is high, a fill in the same cycle is discarded and no victim pointer moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lookupValid | input | 1 | Lookup request strobe |
| lookupVa | input | 14 | Virtual address to translate |
| lookupPid | input | 4 | Process number of the lookup |
| fillValid | input | 1 | Fill request from the walker |
| fillVpn | input | 8 | Virtual page number of the fill |
| fillPid | input | 4 | Process number of the fill |
| fillPpn | input | 6 | Physical frame number of the fill |
| flushAll | input | 1 | Invalidate every entry |
| flushPidValid | input | 1 | Invalidate entries of one process |
| flushPid | input | 4 | Process whose entries are invalidated |
| respValid | output | 1 | Lookup result valid |
| respHit | output | 1 | Lookup hit |
| respPa | output | 12 | Translated physical address, 0 on a miss |

## Verification
The hardest state to reach from the ports is a full set whose victim pointer has moved away from way 0. Reaching it takes a run of fills to a single set with distinct tags. On top of that come in-place refills, which must still advance the pointer, and flush collisions, which must not. The directed part fills one set past its capacity and then refills a resident tag. The random part narrows tags to eight values and processes to four, so sets overflow, entries are overwritten and flushes hit populated sets many times. Every result is compared against a behavioural model kept in the bench.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  // Strobes from the control unit to the entry storage.
  typedef struct packed {
    logic clrAll;  // drop every entry
    logic clrPid;  // drop entries of the named process
    logic wrEn;    // write the chosen way of the fill set
  } xlStrobe_t;
endpackage

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
  import xlate_pkg::*;
#(
  parameter int WAYS = 4,
  parameter int SETS = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int PTR_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fillValid,
  input  logic             flushAll,
  input  logic             flushPidValid,
  input  logic [IDX_W-1:0] fillSet,
  input  logic [WAYS-1:0]  fillSetValid,
  input  logic [WAYS-1:0]  fillMatch,
  output xlStrobe_t        strobe,
  output logic [WAYS-1:0]  wrWay
);
  logic [PTR_W-1:0] rrPtr [SETS];

  // Flushes win over fills.
  always_comb begin
    strobe.clrAll = flushAll;
    strobe.clrPid = flushPidValid && !flushAll;
    strobe.wrEn   = fillValid && !flushAll && !flushPidValid;
  end

  // Victim choice: matching way, then lowest invalid way, then round robin.
  always_comb begin
    logic found;
    found = 1'b0;
    wrWay = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (fillMatch[w] && !found) begin
        wrWay[w] = 1'b1;
        found    = 1'b1;
      end
    end
    for (int w = 0; w < WAYS; w++) begin
      if (!fillSetValid[w] && !found) begin
        wrWay[w] = 1'b1;
        found    = 1'b1;
      end
    end
    if (!found) wrWay[rrPtr[fillSet]] = 1'b1;
  end

  for (genvar s = 0; s < SETS; s++) begin : gPtr
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rrPtr[s] <= '0;
      end else if (strobe.wrEn && fillSet == IDX_W'(s)) begin
        rrPtr[s] <= (rrPtr[s] == PTR_W'(WAYS - 1)) ? '0 : rrPtr[s] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/xlate_store.sv
module xlate_store
  import xlate_pkg::*;
#(
  parameter int VA_W       = 14,
  parameter int PA_W       = 12,
  parameter int OFF_W      = 6,
  parameter int WAYS       = 4,
  parameter int SETS       = 4,
  parameter int PID_W      = 4,
  parameter int PID_TAGGED = 1,
  localparam int VPN_W = VA_W - OFF_W,
  localparam int PPN_W = PA_W - OFF_W,
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = VPN_W - IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  xlStrobe_t        strobe,
  input  logic [WAYS-1:0]  wrWay,
  input  logic             lookupValid,
  input  logic [VA_W-1:0]  lookupVa,
  input  logic [PID_W-1:0] lookupPid,
  input  logic [VPN_W-1:0] fillVpn,
  input  logic [PID_W-1:0] fillPid,
  input  logic [PPN_W-1:0] fillPpn,
  input  logic [PID_W-1:0] flushPid,
  output logic [IDX_W-1:0] fillSet,
  output logic [WAYS-1:0]  fillSetValid,
  output logic [WAYS-1:0]  fillMatch,
  output logic             respValid,
  output logic             respHit,
  output logic [PA_W-1:0]  respPa
);
  logic [SETS-1:0][WAYS-1:0]             validArr;
  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tagArr;
  logic [SETS-1:0][WAYS-1:0][PPN_W-1:0]  ppnArr;
  logic [SETS-1:0][WAYS-1:0][PID_W-1:0]  pidArr;

  logic [TAG_W-1:0] fillTag;
  assign fillSet = fillVpn[IDX_W-1:0];
  assign fillTag = fillVpn[VPN_W-1:IDX_W];

  for (genvar s = 0; s < SETS; s++) begin : gSet
    for (genvar w = 0; w < WAYS; w++) begin : gWay
      logic             vQ;
      logic [TAG_W-1:0] tQ;
      logic [PPN_W-1:0] pQ;
      logic [PID_W-1:0] idQ;
      logic             sel;
      logic             pidHitFlush;
      assign sel         = (fillSet == IDX_W'(s)) && wrWay[w];
      assign pidHitFlush = (PID_TAGGED == 0) || (idQ == flushPid);

      always_ff @(posedge clk) begin
        if (!rst_n)                              vQ <= 1'b0;
        else if (strobe.clrAll)                  vQ <= 1'b0;
        else if (strobe.clrPid && pidHitFlush)   vQ <= 1'b0;
        else if (strobe.wrEn && sel)             vQ <= 1'b1;
      end

      always_ff @(posedge clk) begin
        if (strobe.wrEn && sel) begin
          tQ <= fillTag;
          pQ <= fillPpn;
        end
      end

      if (PID_TAGGED != 0) begin : gPid
        always_ff @(posedge clk) begin
          if (strobe.wrEn && sel) idQ <= fillPid;
        end
      end else begin : gNoPid
        assign idQ = '0;
      end

      assign validArr[s][w] = vQ;
      assign tagArr[s][w]   = tQ;
      assign ppnArr[s][w]   = pQ;
      assign pidArr[s][w]   = idQ;
    end
  end

  // Lookup compare in the indexed set.
  logic [IDX_W-1:0] lkSet;
  logic [TAG_W-1:0] lkTag;
  logic [WAYS-1:0]  lkMatch;
  logic [PPN_W-1:0] lkPpn;
  assign lkSet = lookupVa[OFF_W+IDX_W-1:OFF_W];
  assign lkTag = lookupVa[VA_W-1:OFF_W+IDX_W];

  always_comb begin
    lkPpn = '0;
    for (int w = 0; w < WAYS; w++) begin
      lkMatch[w] = validArr[lkSet][w] && (tagArr[lkSet][w] == lkTag) &&
                   ((PID_TAGGED == 0) || (pidArr[lkSet][w] == lookupPid));
      fillSetValid[w] = validArr[fillSet][w];
      fillMatch[w] = validArr[fillSet][w] && (tagArr[fillSet][w] == fillTag) &&
                     ((PID_TAGGED == 0) || (pidArr[fillSet][w] == fillPid));
      if (lkMatch[w]) lkPpn = lkPpn | ppnArr[lkSet][w];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      respValid <= 1'b0;
      respHit   <= 1'b0;
      respPa    <= '0;
    end else begin
      respValid <= lookupValid;
      respHit   <= lookupValid && (|lkMatch);
      respPa    <= (lookupValid && (|lkMatch)) ? {lkPpn, lookupVa[OFF_W-1:0]} : '0;
    end
  end
endmodule

// File: rtl/xlate_buf.sv
module xlate_buf
  import xlate_pkg::*;
#(
  parameter int VA_W       = 14,
  parameter int PA_W       = 12,
  parameter int OFF_W      = 6,
  parameter int WAYS       = 4,
  parameter int SETS       = 4,
  parameter int PID_W      = 4,
  parameter int PID_TAGGED = 1,
  localparam int VPN_W = VA_W - OFF_W,
  localparam int PPN_W = PA_W - OFF_W,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lookupValid,
  input  logic [VA_W-1:0]  lookupVa,
  input  logic [PID_W-1:0] lookupPid,
  input  logic             fillValid,
  input  logic [VPN_W-1:0] fillVpn,
  input  logic [PID_W-1:0] fillPid,
  input  logic [PPN_W-1:0] fillPpn,
  input  logic             flushAll,
  input  logic             flushPidValid,
  input  logic [PID_W-1:0] flushPid,
  output logic             respValid,
  output logic             respHit,
  output logic [PA_W-1:0]  respPa
);
  xlStrobe_t        strobe;
  logic [WAYS-1:0]  wrWay;
  logic [IDX_W-1:0] fillSet;
  logic [WAYS-1:0]  fillSetValid;
  logic [WAYS-1:0]  fillMatch;

  xlate_ctrl #(.WAYS(WAYS), .SETS(SETS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .fillValid(fillValid), .flushAll(flushAll),
    .flushPidValid(flushPidValid), .fillSet(fillSet), .fillSetValid(fillSetValid),
    .fillMatch(fillMatch), .strobe(strobe), .wrWay(wrWay)
  );

  xlate_store #(
    .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .WAYS(WAYS), .SETS(SETS),
    .PID_W(PID_W), .PID_TAGGED(PID_TAGGED)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .wrWay(wrWay),
    .lookupValid(lookupValid), .lookupVa(lookupVa), .lookupPid(lookupPid),
    .fillVpn(fillVpn), .fillPid(fillPid), .fillPpn(fillPpn), .flushPid(flushPid),
    .fillSet(fillSet), .fillSetValid(fillSetValid), .fillMatch(fillMatch),
    .respValid(respValid), .respHit(respHit), .respPa(respPa)
  );
endmodule

// File: rtl/xlate_buf_chk.sv
module xlate_buf_chk #(
  parameter int VA_W  = 14,
  parameter int PA_W  = 12,
  parameter int OFF_W = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            lookupValid,
  input logic [VA_W-1:0] lookupVa,
  input logic            flushAll,
  input logic            respValid,
  input logic            respHit,
  input logic [PA_W-1:0] respPa
);
  assert_resp_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lookupValid |=> respValid);
  assert_no_resp_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !lookupValid |=> !respValid);
  assert_hit_needs_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    respHit |-> respValid);
  assert_miss_zero_pa_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !respHit |-> (respPa == '0));
  assert_offset_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lookupValid |=> (!respHit || respPa[OFF_W-1:0] == $past(lookupVa[OFF_W-1:0])));
  assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flushAll ##1 lookupValid) |=> !respHit);
endmodule

bind xlate_buf xlate_buf_chk #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lookupValid(lookupValid), .lookupVa(lookupVa),
  .flushAll(flushAll), .respValid(respValid), .respHit(respHit), .respPa(respPa)
);

// File: tb/sim_xlate_buf.sv
module sim_xlate_buf;
  localparam int NS = 4, NW = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lookupValid = 1'b0;
  logic [13:0] lookupVa = '0;
  logic [3:0]  lookupPid = '0;
  logic        fillValid = 1'b0;
  logic [7:0]  fillVpn = '0;
  logic [3:0]  fillPid = '0;
  logic [5:0]  fillPpn = '0;
  logic        flushAll = 1'b0;
  logic        flushPidValid = 1'b0;
  logic [3:0]  flushPid = '0;
  logic        respValid, respHit;
  logic [11:0] respPa;

  int nChecks = 0, nFails = 0, cycles = 0;
  bit done = 0;

  xlate_buf u0 (.*);

  always #4 clk = ~clk;

  // Behavioural model of the entry state
  bit       mV   [NS][NW];
  bit [5:0] mTag [NS][NW];
  bit [3:0] mPid [NS][NW];
  bit [5:0] mPpn [NS][NW];
  int       mRr  [NS];

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void modelLookup(input bit [13:0] va, input bit [3:0] pid,
                                      output bit hit, output bit [11:0] pa);
    int s = int'(va[7:6]);
    hit = 0; pa = '0;
    for (int w = 0; w < NW; w++)
      if (mV[s][w] && mTag[s][w] == va[13:8] && mPid[s][w] == pid) begin
        hit = 1; pa = {mPpn[s][w], va[5:0]};
      end
  endfunction

  function automatic void modelUpdate(bit fv, bit [7:0] vpn, bit [3:0] pid, bit [5:0] ppn,
                                      bit fa, bit fs, bit [3:0] fsp);
    if (fa) begin
      for (int s = 0; s < NS; s++) for (int w = 0; w < NW; w++) mV[s][w] = 0;
    end else if (fs) begin
      for (int s = 0; s < NS; s++) for (int w = 0; w < NW; w++)
        if (mPid[s][w] == fsp) mV[s][w] = 0;
    end else if (fv) begin
      int s = int'(vpn[1:0]);
      int way = -1;
      for (int w = 0; w < NW; w++)
        if (way < 0 && mV[s][w] && mTag[s][w] == vpn[7:2] && mPid[s][w] == pid) way = w;
      for (int w = 0; w < NW; w++)
        if (way < 0 && !mV[s][w]) way = w;
      if (way < 0) way = mRr[s];
      mV[s][way] = 1; mTag[s][way] = vpn[7:2]; mPid[s][way] = pid; mPpn[s][way] = ppn;
      mRr[s] = (mRr[s] + 1) % NW;
    end
  endfunction

  // One cycle: drive at negedge, sample one time unit after the posedge.
  task automatic step(string req, bit lv, bit [13:0] va, bit [3:0] pid,
                      bit fv, bit [7:0] vpn, bit [3:0] fpid, bit [5:0] ppn,
                      bit fa, bit fs, bit [3:0] fsp);
    bit eHit; bit [11:0] ePa;
    lookupValid = lv; lookupVa = va; lookupPid = pid;
    fillValid = fv; fillVpn = vpn; fillPid = fpid; fillPpn = ppn;
    flushAll = fa; flushPidValid = fs; flushPid = fsp;
    modelLookup(va, pid, eHit, ePa);
    modelUpdate(fv, vpn, fpid, ppn, fa, fs, fsp);
    @(posedge clk); #1;
    check({req, " respValid"}, int'(respValid), int'(lv));
    if (lv) begin
      check({req, " respHit"}, int'(respHit), int'(eHit));
      check({req, " respPa"}, int'(respPa), int'(ePa));
    end
    @(negedge clk);
  endtask

  task automatic look(string req, bit [13:0] va, bit [3:0] pid);
    step(req, 1, va, pid, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic fill(string req, bit [7:0] vpn, bit [3:0] pid, bit [5:0] ppn);
    step(req, 0, 0, 0, 1, vpn, pid, ppn, 0, 0, 0);
  endtask

  initial begin : watchdog
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        nChecks++; nFails++;
        $display("FAIL watchdog actual=%0d expected<100000", cycles);
        $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5eed1));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 respValid", int'(respValid), 0);
    check("R1 respHit", int'(respHit), 0);
    check("R1 respPa", int'(respPa), 0);
    look("R1 empty miss", 14'h0123, 4'd1);
    look("R5 miss pa zero", 14'h3fff, 4'd0);

    // R9 fill and lookup in the same cycle: old contents
    step("R9 fill same cycle", 1, {8'h0D, 6'h25}, 4'd1, 1, 8'h0D, 4'd1, 6'h2D, 0, 0, 0);
    look("R2 hit pa", {8'h0D, 6'h25}, 4'd1);
    look("R4 other pid miss", {8'h0D, 6'h25}, 4'd2);
    step("R3 idle", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);

    // R6 / R7 set 2 fills and overflow
    for (int i = 0; i < 4; i++) fill("R6 fill", {6'(i + 1), 2'd2}, 4'd1, 6'(8 + i));
    for (int i = 0; i < 4; i++) look("R6 resident", {6'(i + 1), 2'd2, 6'h07}, 4'd1);
    fill("R7 evict", {6'd9, 2'd2}, 4'd1, 6'h30);
    look("R7 evicted miss", {6'd1, 2'd2, 6'h00}, 4'd1);
    look("R7 newcomer hit", {6'd9, 2'd2, 6'h11}, 4'd1);
    look("R7 survivor hit", {6'd2, 2'd2, 6'h11}, 4'd1);
    fill("R7 second evict", {6'd10, 2'd2}, 4'd1, 6'h31);
    look("R7 way1 evicted", {6'd2, 2'd2, 6'h00}, 4'd1);

    // R8 refill in place
    fill("R8 refill", {6'd3, 2'd2}, 4'd1, 6'h3A);
    look("R8 new ppn", {6'd3, 2'd2, 6'h05}, 4'd1);
    look("R8 neighbour kept", {6'd4, 2'd2, 6'h05}, 4'd1);

    // R11 selective flush
    fill("R11 pid2 fill", 8'h40, 4'd2, 6'h15);
    step("R11 flush pid1", 0, 0, 0, 0, 0, 0, 0, 0, 1, 4'd1);
    look("R11 pid1 gone", {8'h0D, 6'h01}, 4'd1);
    look("R11 pid2 kept", {8'h40, 6'h01}, 4'd2);

    // R12 flush beats fill; R9 lookup with flush sees old contents
    step("R9 lookup during flush", 1, {8'h40, 6'h02}, 4'd2, 1, 8'h55, 4'd3, 6'h22, 1, 0, 0);
    look("R12 fill dropped", {8'h55, 6'h02}, 4'd3);
    look("R10 all gone", {8'h40, 6'h02}, 4'd2);
    fill("R12 pointer", {6'd1, 2'd3}, 4'd3, 6'h01);
    step("R12 fill vs selective", 0, 0, 0, 1, {6'd2, 2'd3}, 4'd3, 6'h02, 0, 1, 4'd0);
    look("R12 dropped under sel", {6'd2, 2'd3, 6'h00}, 4'd3);
    look("R11 other pid kept", {6'd1, 2'd3, 6'h00}, 4'd3);

    // Random mix (R4 R6 R7 R8 R10 R11 R12)
    for (int n = 0; n < 4000; n++) begin
      bit [13:0] va  = {3'($urandom_range(7)), 3'b000, 2'($urandom_range(3)), 6'($urandom)};
      bit [7:0]  vpn = {3'($urandom_range(7)), 3'b000, 2'($urandom_range(3))};
      int r = $urandom_range(99);
      step("R4 random", ($urandom_range(9) < 8), va, 4'($urandom_range(3)),
           (r < 45), vpn, 4'($urandom_range(3)), 6'($urandom),
           (r >= 97), (r >= 92 && r < 97), 4'($urandom_range(3)));
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule